// File: doc/BRIEF.md
# ADC Result Offset and Limit Checker

This block takes each sample from an analog-to-digital converter and turns it into an offset-corrected, signed result for the result slot it belongs to. Every slot has its own 12-bit offset, which is subtracted from the sample to give a 13-bit two's-complement result. That result is stored in the slot. It is also compared against the slot's own high and low limits, and its sign is checked against the slot's previous result to detect a crossing of zero.

Each slot keeps three sticky event flags: high limit, low limit and zero crossing. Software clears them with write-one-to-clear pulses. All flags of all slots are merged into one interrupt request. A processor can replace the converter data with a test value of its own. This lets the limit and crossing logic be exercised without an analog input. Register decode and the converter itself sit outside the block. Offsets and limits arrive here as flat configuration vectors.

Top module: `adc_pp_top`

## Requirements
- R1: After reset, all stored results are zero, all high, low and crossing flags are clear, and `irq` is low.
- R2: When `smp_valid` is high at a rising clock edge, the slot selected by `smp_slot` stores (sample − offset of that slot) as a 13-bit two's-complement value in `res_data[slot*13 +: 13]`. The offset is the slot's field `cfg_offset[slot*12 +: 12]`, taken as unsigned. The stored value is visible after that edge.
- R3: When `tst_sel` is high, the sample used is `tst_data` and `smp_data` is ignored. When `tst_sel` is low, the sample used is `smp_data`.
- R4: The slot's high flag `hi_flag[slot]` is set when the new result is strictly greater than the sign-extended 12-bit limit `cfg_hi_lim[slot*12 +: 12]`, compared as signed values. A result equal to the limit does not set it.
- R5: The slot's low flag `lo_flag[slot]` is set when the new result is strictly less than the sign-extended 12-bit limit `cfg_lo_lim[slot*12 +: 12]`, compared as signed values. A result equal to the limit does not set it.
- R6: The slot's crossing flag `zc_flag[slot]` is set when the sign bit (bit 12) of the new result differs from the sign bit of the slot's previous result. Zero counts as non-negative. The first sample a slot receives after reset never sets it.
- R7: A set flag stays set until its bit in `clr_hi`, `clr_lo` or `clr_zc` is pulsed high at a clock edge. If a new event and a clear for the same flag meet at the same edge, the flag ends up set.
- R8: `irq` is high exactly when at least one flag of any slot is set. It follows the flag registers in the same cycle.
- R9: A sample for one slot leaves the stored results, flags and sign history of every other slot unchanged.
- R10: Without `smp_valid`, changes on `smp_slot`, `smp_data`, `tst_sel` and `tst_data` leave all results and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_slot | input | SLOT_W | Result slot of the sample |
| smp_data | input | SMP_W | Converter sample, unsigned |
| tst_sel | input | 1 | Use the test value instead of converter data |
| tst_data | input | SMP_W | Processor-supplied test sample |
| cfg_offset | input | NUM_SLOTS*SMP_W | Per-slot unsigned offset, slot i at [i*SMP_W +: SMP_W] |
| cfg_hi_lim | input | NUM_SLOTS*SMP_W | Per-slot signed high limit |
| cfg_lo_lim | input | NUM_SLOTS*SMP_W | Per-slot signed low limit |
| clr_hi | input | NUM_SLOTS | Write-one-to-clear for the high flags |
| clr_lo | input | NUM_SLOTS | Write-one-to-clear for the low flags |
| clr_zc | input | NUM_SLOTS | Write-one-to-clear for the crossing flags |
| res_data | output | NUM_SLOTS*(SMP_W+1) | Stored signed results, slot i at [i*(SMP_W+1) +: SMP_W+1] |
| hi_flag | output | NUM_SLOTS | Sticky high-limit flags |
| lo_flag | output | NUM_SLOTS | Sticky low-limit flags |
| zc_flag | output | NUM_SLOTS | Sticky zero-crossing flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with four slots and a 12-bit sample. A two-bit slot index then reaches the top slot, and it can show that traffic in one slot leaves its neighbours alone. At the full 12-bit width, both ends of the result range can be reached directly: a zero sample against the largest offset gives −4095, and a full-scale sample against a zero offset gives +4095. The same width places each limit exactly on the result, where a strict compare must stay quiet. A sign flip across those two extremes also exercises the crossing flag at the widest swing.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

    // One bit per event kind, used for both set and clear vectors of a slot.
    typedef struct packed {
        logic hi;
        logic lo;
        logic zc;
    } evt_t;

    localparam evt_t EVT_NONE = '{hi: 1'b0, lo: 1'b0, zc: 1'b0};

endpackage

// File: rtl/adc_pp_src_sel.sv
module adc_pp_src_sel #(
    parameter int SMP_W = 12
) (
    input  logic             tst_sel,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0] tst_data,
    output logic [SMP_W-1:0] sel_data
);

    always_comb begin
        if (tst_sel) begin
            sel_data = tst_data;
        end else begin
            sel_data = smp_data;
        end
    end

endmodule

// File: rtl/adc_pp_calc.sv
module adc_pp_calc #(
    parameter int SMP_W = 12,
    localparam int RES_W = SMP_W + 1
) (
    input  logic [SMP_W-1:0] sample,
    input  logic [SMP_W-1:0] offset,
    input  logic [SMP_W-1:0] hi_lim,
    input  logic [SMP_W-1:0] lo_lim,
    output logic [RES_W-1:0] result,
    output logic             hi_evt,
    output logic             lo_evt
);

    logic signed [RES_W-1:0] res_s;
    logic signed [RES_W-1:0] hi_ext;
    logic signed [RES_W-1:0] lo_ext;

    always_comb begin
        // Zero-extend both operands so the difference spans the full signed range.
        res_s  = $signed({1'b0, sample}) - $signed({1'b0, offset});
        hi_ext = $signed({hi_lim[SMP_W-1], hi_lim});
        lo_ext = $signed({lo_lim[SMP_W-1], lo_lim});
        result = res_s;
        hi_evt = res_s > hi_ext;
        lo_evt = res_s < lo_ext;
    end

endmodule

// File: rtl/adc_pp_slot.sv
module adc_pp_slot
    import adc_pp_pkg::*;
#(
    parameter int RES_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] result,
    input  logic             hi_evt,
    input  logic             lo_evt,
    input  evt_t             clr,
    output logic [RES_W-1:0] res_q,
    output evt_t             flags_q
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             seen;
        evt_t             flags;
    } slot_st_t;

    slot_st_t st_d, st_q;
    evt_t     set_v;

    always_comb begin
        set_v = EVT_NONE;
        st_d  = st_q;
        if (load) begin
            set_v.hi = hi_evt;
            set_v.lo = lo_evt;
            set_v.zc = st_q.seen && (result[RES_W-1] != st_q.res[RES_W-1]);
            st_d.res  = result;
            st_d.seen = 1'b1;
        end
        // Clear first, then set: a same-cycle event wins over the clear.
        st_d.flags = (st_q.flags & ~clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign flags_q = st_q.flags;

endmodule

// File: rtl/adc_pp_top.sv
module adc_pp_top
    import adc_pp_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SMP_W     = 12,
    localparam int RES_W    = SMP_W + 1,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [SLOT_W-1:0]          smp_slot,
    input  logic [SMP_W-1:0]           smp_data,
    input  logic                       tst_sel,
    input  logic [SMP_W-1:0]           tst_data,
    input  logic [NUM_SLOTS*SMP_W-1:0] cfg_offset,
    input  logic [NUM_SLOTS*SMP_W-1:0] cfg_hi_lim,
    input  logic [NUM_SLOTS*SMP_W-1:0] cfg_lo_lim,
    input  logic [NUM_SLOTS-1:0]       clr_hi,
    input  logic [NUM_SLOTS-1:0]       clr_lo,
    input  logic [NUM_SLOTS-1:0]       clr_zc,
    output logic [NUM_SLOTS*RES_W-1:0] res_data,
    output logic [NUM_SLOTS-1:0]       hi_flag,
    output logic [NUM_SLOTS-1:0]       lo_flag,
    output logic [NUM_SLOTS-1:0]       zc_flag,
    output logic                       irq
);

    logic [SMP_W-1:0] sel_data;
    logic [SMP_W-1:0] cur_off;
    logic [SMP_W-1:0] cur_hi;
    logic [SMP_W-1:0] cur_lo;
    logic [RES_W-1:0] calc_res;
    logic             calc_hi;
    logic             calc_lo;

    adc_pp_src_sel #(.SMP_W(SMP_W)) u_src (
        .tst_sel  (tst_sel),
        .smp_data (smp_data),
        .tst_data (tst_data),
        .sel_data (sel_data)
    );

    // Pick the configuration fields of the addressed slot.
    always_comb begin
        cur_off = '0;
        cur_hi  = '0;
        cur_lo  = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (smp_slot == SLOT_W'(k)) begin
                cur_off = cfg_offset[k*SMP_W +: SMP_W];
                cur_hi  = cfg_hi_lim[k*SMP_W +: SMP_W];
                cur_lo  = cfg_lo_lim[k*SMP_W +: SMP_W];
            end
        end
    end

    adc_pp_calc #(.SMP_W(SMP_W)) u_calc (
        .sample (sel_data),
        .offset (cur_off),
        .hi_lim (cur_hi),
        .lo_lim (cur_lo),
        .result (calc_res),
        .hi_evt (calc_hi),
        .lo_evt (calc_lo)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        evt_t clr_i;
        evt_t flg_i;
        logic ld_i;

        assign ld_i     = smp_valid && (smp_slot == SLOT_W'(i));
        assign clr_i.hi = clr_hi[i];
        assign clr_i.lo = clr_lo[i];
        assign clr_i.zc = clr_zc[i];

        adc_pp_slot #(.RES_W(RES_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (ld_i),
            .result  (calc_res),
            .hi_evt  (calc_hi),
            .lo_evt  (calc_lo),
            .clr     (clr_i),
            .res_q   (res_data[i*RES_W +: RES_W]),
            .flags_q (flg_i)
        );

        assign hi_flag[i] = flg_i.hi;
        assign lo_flag[i] = flg_i.lo;
        assign zc_flag[i] = flg_i.zc;
    end

    assign irq = |{hi_flag, lo_flag, zc_flag};

endmodule

module adc_pp_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int RES_W     = 13
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic [NUM_SLOTS-1:0]       clr_hi,
    input logic [NUM_SLOTS-1:0]       clr_lo,
    input logic [NUM_SLOTS-1:0]       clr_zc,
    input logic [NUM_SLOTS*RES_W-1:0] res_data,
    input logic [NUM_SLOTS-1:0]       hi_flag,
    input logic [NUM_SLOTS-1:0]       lo_flag,
    input logic [NUM_SLOTS-1:0]       zc_flag,
    input logic                       irq
);

    logic [NUM_SLOTS-1:0] any_flag;
    assign any_flag = hi_flag | lo_flag | zc_flag;

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!irq && any_flag == '0); // R1
        end
    end

    AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hi_flag & $past(hi_flag & ~clr_hi)) == $past(hi_flag & ~clr_hi))); // R7
    AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lo_flag & $past(lo_flag & ~clr_lo)) == $past(lo_flag & ~clr_lo))); // R7
    AST_ZC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((zc_flag & $past(zc_flag & ~clr_zc)) == $past(zc_flag & ~clr_zc))); // R7
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ((any_flag & ~$past(any_flag)) == '0)); // R10
    AST_IDLE_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(res_data)); // R10
    AST_ONE_SLOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0(any_flag & ~$past(any_flag))); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(smp_valid)); // R8

endmodule

bind adc_pp_top adc_pp_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .RES_W     (RES_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .clr_hi    (clr_hi),
    .clr_lo    (clr_lo),
    .clr_zc    (clr_zc),
    .res_data  (res_data),
    .hi_flag   (hi_flag),
    .lo_flag   (lo_flag),
    .zc_flag   (zc_flag),
    .irq       (irq)
);

// File: tb/adc_pp_top_test.sv
module adc_pp_top_test;

    localparam int NS = 4;
    localparam int SW = 12;
    localparam int RW = SW + 1;
    localparam int LW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [LW-1:0]    smp_slot = '0;
    logic [SW-1:0]    smp_data = '0;
    logic             tst_sel = 1'b0;
    logic [SW-1:0]    tst_data = '0;
    logic [NS*SW-1:0] cfg_offset;
    logic [NS*SW-1:0] cfg_hi_lim;
    logic [NS*SW-1:0] cfg_lo_lim;
    logic [NS-1:0]    clr_hi = '0;
    logic [NS-1:0]    clr_lo = '0;
    logic [NS-1:0]    clr_zc = '0;
    logic [NS*RW-1:0] res_data;
    logic [NS-1:0]    hi_flag;
    logic [NS-1:0]    lo_flag;
    logic [NS-1:0]    zc_flag;
    logic             irq;

    logic [SW-1:0] off_m [NS];
    logic [SW-1:0] hi_m  [NS];
    logic [SW-1:0] lo_m  [NS];
    logic [RW-1:0] e_res [NS];
    logic          e_hi  [NS];
    logic          e_lo  [NS];
    logic          e_zc  [NS];
    logic          seen  [NS];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NS; k++) begin
            cfg_offset[k*SW +: SW] = off_m[k];
            cfg_hi_lim[k*SW +: SW] = hi_m[k];
            cfg_lo_lim[k*SW +: SW] = lo_m[k];
        end
    end

    adc_pp_top #(.NUM_SLOTS(NS), .SMP_W(SW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_slot   (smp_slot),
        .smp_data   (smp_data),
        .tst_sel    (tst_sel),
        .tst_data   (tst_data),
        .cfg_offset (cfg_offset),
        .cfg_hi_lim (cfg_hi_lim),
        .cfg_lo_lim (cfg_lo_lim),
        .clr_hi     (clr_hi),
        .clr_lo     (clr_lo),
        .clr_zc     (clr_zc),
        .res_data   (res_data),
        .hi_flag    (hi_flag),
        .lo_flag    (lo_flag),
        .zc_flag    (zc_flag),
        .irq        (irq)
    );

    task automatic cmp(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic any_e;
        any_e = 1'b0;
        for (int k = 0; k < NS; k++) begin
            cmp(req, $sformatf("res[%0d]", k), int'($signed(res_data[k*RW +: RW])), int'($signed(e_res[k])));
            cmp(req, $sformatf("hi[%0d]", k), int'(hi_flag[k]), int'(e_hi[k]));
            cmp(req, $sformatf("lo[%0d]", k), int'(lo_flag[k]), int'(e_lo[k]));
            cmp(req, $sformatf("zc[%0d]", k), int'(zc_flag[k]), int'(e_zc[k]));
            any_e = any_e | e_hi[k] | e_lo[k] | e_zc[k];
        end
        cmp(req, "irq", int'(irq), int'(any_e));
    endtask

    // Apply the flag clears to the model (clear before set).
    task automatic model_clear(logic [NS-1:0] ch, logic [NS-1:0] cl, logic [NS-1:0] cz);
        for (int k = 0; k < NS; k++) begin
            if (ch[k]) e_hi[k] = 1'b0;
            if (cl[k]) e_lo[k] = 1'b0;
            if (cz[k]) e_zc[k] = 1'b0;
        end
    endtask

    task automatic send(int slot, logic [SW-1:0] data, bit use_tst,
                        logic [NS-1:0] ch, logic [NS-1:0] cl, logic [NS-1:0] cz, string req);
        logic signed [RW-1:0] r;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_slot  = LW'(slot);
        tst_sel   = use_tst;
        smp_data  = use_tst ? ~data : data;
        tst_data  = use_tst ? data : ~data;
        clr_hi = ch; clr_lo = cl; clr_zc = cz;
        r = $signed({1'b0, data}) - $signed({1'b0, off_m[slot]});
        model_clear(ch, cl, cz);
        if (r > $signed({hi_m[slot][SW-1], hi_m[slot]})) e_hi[slot] = 1'b1;
        if (r < $signed({lo_m[slot][SW-1], lo_m[slot]})) e_lo[slot] = 1'b1;
        if (seen[slot] && (r[RW-1] != e_res[slot][RW-1])) e_zc[slot] = 1'b1;
        e_res[slot] = r;
        seen[slot]  = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        clr_hi = '0; clr_lo = '0; clr_zc = '0;
        check_all(req);
    endtask

    task automatic clear(logic [NS-1:0] ch, logic [NS-1:0] cl, logic [NS-1:0] cz, string req);
        @(negedge clk);
        clr_hi = ch; clr_lo = cl; clr_zc = cz;
        model_clear(ch, cl, cz);
        @(negedge clk);
        clr_hi = '0; clr_lo = '0; clr_zc = '0;
        check_all(req);
    endtask

    task automatic t_reset;
        for (int k = 0; k < NS; k++) begin
            e_res[k] = '0; e_hi[k] = 1'b0; e_lo[k] = 1'b0; e_zc[k] = 1'b0; seen[k] = 1'b0;
            off_m[k] = '0; hi_m[k] = 12'h7FF; lo_m[k] = 12'h800;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic t_offset;
        off_m[0] = 12'd100;
        send(0, 12'd500, 1'b0, '0, '0, '0, "R2");          // 400
        off_m[1] = 12'd1000;
        send(1, 12'd10, 1'b0, '0, '0, '0, "R2_R6");        // -990, first sample
    endtask

    task automatic t_cross;
        send(1, 12'd2000, 1'b0, '0, '0, '0, "R6");         // 1000, sign flip
        send(1, 12'd1000, 1'b0, '0, '0, '0, "R6");         // 0 stays non-negative
        clear('0, '0, 4'b0010, "R7_R8");
    endtask

    task automatic t_limits;
        off_m[2] = 12'd200;
        hi_m[2]  = 12'd300;
        lo_m[2]  = 12'hFCE;                                // -50
        send(2, 12'd500, 1'b0, '0, '0, '0, "R4");          // 300, equal: no set
        send(2, 12'd501, 1'b0, '0, '0, '0, "R4");          // 301
        send(2, 12'd150, 1'b0, '0, '0, '0, "R5");          // -50, equal: no set
        send(2, 12'd149, 1'b0, '0, '0, '0, "R5");          // -51
        clear(4'b0100, 4'b0100, 4'b0100, "R7");
    endtask

    task automatic t_test_data;
        send(0, 12'd77, 1'b1, '0, '0, '0, "R3");
        send(0, 12'd900, 1'b0, '0, '0, '0, "R3");
    endtask

    task automatic t_idle;
        @(negedge clk);
        smp_slot = 2'd2; smp_data = 12'hFFF; tst_sel = 1'b1; tst_data = 12'h000;
        @(negedge clk);
        smp_slot = 2'd1; smp_data = 12'h000; tst_sel = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R10");
    endtask

    task automatic t_set_wins;
        hi_m[2] = 12'd0;
        send(2, 12'd300, 1'b0, 4'b0100, '0, '0, "R7");     // 100 > 0 while clearing
        clear(4'b0100, '0, '0, "R7");
    endtask

    task automatic t_extremes;
        off_m[3] = 12'hFFF;
        send(3, 12'd0, 1'b0, '0, '0, '0, "R2_R9");         // -4095
        off_m[3] = 12'd0;
        send(3, 12'hFFF, 1'b0, '0, '0, '0, "R6_R9");       // +4095
        clear('1, '1, '1, "R8");
    endtask

    initial begin
        t_reset();
        t_offset();
        t_cross();
        t_limits();
        t_test_data();
        t_idle();
        t_set_wins();
        t_extremes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule